// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Interrupt Registers

This block is a bus-attached serial port for an APB peripheral bus. Software places one byte at a time into a transmit holding register, and the block shifts it out as a frame with no parity: one start bit, eight data bits and one stop bit. Frames arriving on the receive line are assembled into a single receive holding register, which software empties by reading it. Each holding register holds one byte. If a byte lands on top of one that is still held, a sticky overrun flag is raised.

Bit timing comes from a 20-bit divider of the bus clock. Each serial bit lasts exactly the programmed number of clock cycles. A divider below 16 is treated as invalid, and while it is invalid no frame is sent or received. The block has four interrupt lines: transmit done, receive done, transmit overrun and receive overrun. A fifth line is the OR of the four. Status bits are cleared by writing ones to them.

There is no stream handshake on either side. The serial line cannot apply back-pressure, and software is expected to pace itself against the full flags. A byte that arrives while the receive register is occupied is dropped and recorded as an overrun.

Top module: `apb_serial_port`

## Requirements
- R1: The control register at offset 0x008 keeps only bits [6:0] of a write. Its bits are: bit0 transmit enable, bit1 receive enable, bit2 transmit-done interrupt enable, bit3 receive-done interrupt enable, bit4 transmit-overrun interrupt enable, bit5 receive-overrun interrupt enable.
- R2: A write to the data register at offset 0x000 always loads bits [7:0] into the transmit holding register and sets transmit-full, which is bit0 of the status register at offset 0x004. If transmit-full was already set and the transmitter did not take the byte in that cycle, transmit-overrun is also set (status bit2) and the held byte is replaced.
- R3: A frame starts only while transmit enable is set, transmit-full is set and the divider is valid. Taking the byte clears transmit-full. The line then goes low for the start bit, carries the 8 data bits LSB first, and ends with a high stop bit. Each bit lasts divider clocks, and the line idles high.
- R4: When the transmitter takes a byte and transmit-done interrupt enable is set, interrupt status bit0 (offset 0x00C) is set. It stays set until cleared.
- R5: A received frame is ignored while receive enable is clear. If receive-full (status bit1) is set, the new byte is discarded and receive-overrun (status bit3) is set. Otherwise the byte is stored and receive-full is set.
- R6: A read of the data register returns the received byte in bits [7:0] and clears receive-full.
- R7: Storing a received byte with receive-done interrupt enable set sets interrupt status bit1. It stays set until cleared.
- R8: Interrupt status bit2 equals transmit-overrun AND control bit4. Interrupt status bit3 equals receive-overrun AND control bit5. Both follow any change of either term.
- R9: A write to the status register clears the overrun flags (bits 2 and 3) written as one. A write to the interrupt status register clears the status bits written as one, and also clears the overrun flags at bits 2 and 3.
- R10: The divider register at offset 0x010 keeps bits [19:0] of a write. A value below 16 blocks both transmission and reception.
- R11: Outputs irq_tx, irq_rx, irq_tx_ovr and irq_rx_ovr follow interrupt status bits 0 to 3. irq_any is their OR.
- R12: Reset clears every register and both buffers, and holds the transmit line high. Reads of any offset other than the five above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive-done interrupt |
| irq_tx_ovr | output | 1 | Transmit-overrun interrupt |
| irq_rx_ovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of all interrupt status bits |

## Verification
A stale full flag shows up in two ways. A lost transmit-full produces no start bit on txd. A lost receive-full produces a missing overrun on the next frame. Both appear within one frame time, which is ten times the divider. A wrong overrun or interrupt status bit appears on the irq pins in the cycle after the bus write or line event that caused it, because the overrun lines are level functions of registered state and the status is also readable. Wrong shift order or bit timing corrupts the decoded byte or the stop bit in the same frame.

// File: rtl/apb_serial_pkg.sv
package apb_serial_pkg;
  localparam int OFS_DATA    = 'h000;
  localparam int OFS_STATUS  = 'h004;
  localparam int OFS_CONTROL = 'h008;
  localparam int OFS_IRQSTAT = 'h00C;
  localparam int OFS_DIVIDER = 'h010;

  localparam int CTL_W        = 7;
  localparam int CTL_TX_EN    = 0;
  localparam int CTL_RX_EN    = 1;
  localparam int CTL_TX_IE    = 2;
  localparam int CTL_RX_IE    = 3;
  localparam int CTL_TXOVR_IE = 4;
  localparam int CTL_RXOVR_IE = 5;

  localparam int ST_TX_FULL = 0;
  localparam int ST_RX_FULL = 1;
  localparam int ST_TX_OVR  = 2;
  localparam int ST_RX_OVR  = 3;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_phase_e;
endpackage

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pending,
  input  logic              div_ok,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DATA_W-1:0] byte_in,
  output logic              take,
  output logic              txd
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic              busy_q;
  logic [FRAME-1:0]  shift_q;
  logic [DIV_W-1:0]  tick_q;
  logic [DIV_W-1:0]  period_q;
  logic [CNT_W-1:0]  left_q;

  assign take = !busy_q && enable && pending && div_ok;
  assign txd  = busy_q ? shift_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      shift_q  <= '1;
      tick_q   <= '0;
      period_q <= '0;
      left_q   <= '0;
    end else if (take) begin
      busy_q   <= 1'b1;
      shift_q  <= {1'b1, byte_in, 1'b0};
      tick_q   <= '0;
      period_q <= divisor;
      left_q   <= CNT_W'(FRAME);
    end else if (busy_q) begin
      if (tick_q == period_q - DIV_W'(1)) begin
        tick_q  <= '0;
        shift_q <= {1'b1, shift_q[FRAME-1:1]};
        left_q  <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        tick_q <= tick_q + DIV_W'(1);
      end
    end
  end

  // R3: a frame never restarts while one is still on the line
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (left_q > CNT_W'(1)) |=> busy_q);
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import apb_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              div_ok,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [1:0]        sync_q;
  logic              line;
  rx_phase_e         phase_q;
  logic [DIV_W-1:0]  tick_q;
  logic [DIV_W-1:0]  period_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;

  assign line = sync_q[1];
  assign data = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= RX_IDLE;
      tick_q   <= '0;
      period_q <= '0;
      bit_q    <= '0;
      shift_q  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        RX_IDLE: begin
          if (enable && div_ok && !line) begin
            phase_q  <= RX_START;
            tick_q   <= '0;
            period_q <= divisor;
          end
        end
        RX_START: begin
          if (tick_q == (period_q >> 1) - DIV_W'(1)) begin
            tick_q  <= '0;
            bit_q   <= '0;
            phase_q <= line ? RX_IDLE : RX_BITS;
          end else begin
            tick_q <= tick_q + DIV_W'(1);
          end
        end
        RX_BITS: begin
          if (tick_q == period_q - DIV_W'(1)) begin
            tick_q  <= '0;
            shift_q <= {line, shift_q[DATA_W-1:1]};
            bit_q   <= bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(DATA_W - 1)) phase_q <= RX_STOP;
          end else begin
            tick_q <= tick_q + DIV_W'(1);
          end
        end
        default: begin
          if (tick_q == period_q - DIV_W'(1)) begin
            tick_q  <= '0;
            done    <= line;
            phase_q <= RX_IDLE;
          end else begin
            tick_q <= tick_q + DIV_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/apb_serial_regs.sv
module apb_serial_regs
  import apb_serial_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              tx_take,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_en,
  output logic              rx_en,
  output logic              tx_pending,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DIV_W-1:0]  divisor,
  output logic              div_ok,
  output logic [3:0]        irq_vec
);
  logic              acc, wr, rd;
  logic              wr_data, wr_stat, wr_ctl, wr_irq, wr_div, rd_data;
  logic [CTL_W-1:0]  ctl_q;
  logic              tx_full_q, rx_full_q, tx_ovr_q, rx_ovr_q;
  logic              ist_tx_q, ist_rx_q;
  logic [DATA_W-1:0] txbuf_q, rxbuf_q;
  logic [DIV_W-1:0]  div_q;
  logic              rx_full_eff, rx_store, rx_lost, tx_lost;
  logic              clr_txovr, clr_rxovr;
  logic [3:0]        status;
  logic              unused_wdata;

  assign acc = psel && penable;
  assign wr  = acc && pwrite;
  assign rd  = acc && !pwrite;

  assign wr_data = wr && (paddr == ADDR_W'(OFS_DATA));
  assign wr_stat = wr && (paddr == ADDR_W'(OFS_STATUS));
  assign wr_ctl  = wr && (paddr == ADDR_W'(OFS_CONTROL));
  assign wr_irq  = wr && (paddr == ADDR_W'(OFS_IRQSTAT));
  assign wr_div  = wr && (paddr == ADDR_W'(OFS_DIVIDER));
  assign rd_data = rd && (paddr == ADDR_W'(OFS_DATA));

  assign unused_wdata = ^pwdata[31:DIV_W];

  assign tx_en      = ctl_q[CTL_TX_EN];
  assign rx_en      = ctl_q[CTL_RX_EN];
  assign tx_pending = tx_full_q;
  assign tx_byte    = txbuf_q;
  assign divisor    = div_q;
  assign div_ok     = div_q >= DIV_W'(MIN_DIV);

  assign rx_full_eff = rx_full_q && !rd_data;
  assign rx_store    = rx_done && rx_en && !rx_full_eff;
  assign rx_lost     = rx_done && rx_en && rx_full_eff;
  assign tx_lost     = wr_data && tx_full_q && !tx_take;
  assign clr_txovr   = (wr_stat || wr_irq) && pwdata[ST_TX_OVR];
  assign clr_rxovr   = (wr_stat || wr_irq) && pwdata[ST_RX_OVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      div_q     <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_ovr_q  <= 1'b0;
      rx_ovr_q  <= 1'b0;
      ist_tx_q  <= 1'b0;
      ist_rx_q  <= 1'b0;
      txbuf_q   <= '0;
      rxbuf_q   <= '0;
    end else begin
      if (wr_ctl) ctl_q <= pwdata[CTL_W-1:0];
      if (wr_div) div_q <= pwdata[DIV_W-1:0];
      if (wr_data) txbuf_q <= pwdata[DATA_W-1:0];
      if (rx_store) rxbuf_q <= rx_byte;
      tx_full_q <= (tx_full_q && !tx_take) || wr_data;
      rx_full_q <= rx_full_eff || rx_store;
      tx_ovr_q  <= tx_lost || (tx_ovr_q && !clr_txovr);
      rx_ovr_q  <= rx_lost || (rx_ovr_q && !clr_rxovr);
      ist_tx_q  <= (tx_take && ctl_q[CTL_TX_IE]) || (ist_tx_q && !(wr_irq && pwdata[0]));
      ist_rx_q  <= (rx_store && ctl_q[CTL_RX_IE]) || (ist_rx_q && !(wr_irq && pwdata[1]));
    end
  end

  assign irq_vec = {rx_ovr_q && ctl_q[CTL_RXOVR_IE],
                    tx_ovr_q && ctl_q[CTL_TXOVR_IE],
                    ist_rx_q, ist_tx_q};

  always_comb begin
    status = '0;
    status[ST_TX_FULL] = tx_full_q;
    status[ST_RX_FULL] = rx_full_q;
    status[ST_TX_OVR]  = tx_ovr_q;
    status[ST_RX_OVR]  = rx_ovr_q;
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (paddr == ADDR_W'(OFS_DATA))         prdata = 32'(rxbuf_q);
      else if (paddr == ADDR_W'(OFS_STATUS))  prdata = 32'(status);
      else if (paddr == ADDR_W'(OFS_CONTROL)) prdata = 32'(ctl_q);
      else if (paddr == ADDR_W'(OFS_IRQSTAT)) prdata = 32'(irq_vec);
      else if (paddr == ADDR_W'(OFS_DIVIDER)) prdata = 32'(div_q);
    end
  end

  // R2: a data write always leaves the holding register full
  assert_txfull_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_full_q);
  // R2: writing over an untaken byte records an overrun
  assert_txovr_on_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && tx_full_q && !tx_take |=> tx_ovr_q);
  // R6: reading the data register empties the receive holding register
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !rx_done |=> !rx_full_q);
  // R5: a frame arriving while reception is off leaves the buffer alone
  assert_rx_off_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_en |=> $stable(rxbuf_q));
  // R7: receive-done status only rises when its enable was set
  assert_rxint_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_rx_q) |-> $past(ctl_q[CTL_RX_IE]) && $past(rx_done));
endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_tx_ovr,
  output logic              irq_rx_ovr,
  output logic              irq_any
);
  logic              tx_take, rx_done, tx_en, rx_en, tx_pending, div_ok;
  logic [DATA_W-1:0] rx_byte, tx_byte;
  logic [DIV_W-1:0]  divisor;
  logic [3:0]        irq_vec;

  apb_serial_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .tx_take(tx_take), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_en(tx_en), .rx_en(rx_en), .tx_pending(tx_pending), .tx_byte(tx_byte),
    .divisor(divisor), .div_ok(div_ok), .irq_vec(irq_vec)
  );

  serial_tx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(tx_en), .pending(tx_pending),
    .div_ok(div_ok), .divisor(divisor), .byte_in(tx_byte),
    .take(tx_take), .txd(txd)
  );

  serial_rx_sampler #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .div_ok(div_ok),
    .divisor(divisor), .rxd(rxd), .done(rx_done), .data(rx_byte)
  );

  assign irq_tx     = irq_vec[0];
  assign irq_rx     = irq_vec[1];
  assign irq_tx_ovr = irq_vec[2];
  assign irq_rx_ovr = irq_vec[3];
  assign irq_any    = |irq_vec;

  // R3: taking a byte puts the start bit on the line next cycle
  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !txd);
  // R11: the combined line drops only when no source is left
  assert_any_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_any) |-> !irq_tx && !irq_rx && !irq_tx_ovr && !irq_rx_ovr);
endmodule

// File: tb/apb_serial_port_bench.sv
module apb_serial_port_bench;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        rxd = 1'b1;
  logic        txd, irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  apb_serial_port u_apb_serial_port (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tx_ovr(irq_tx_ovr),
    .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic line_send(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (DIV - 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic line_grab(input string req, input logic [7:0] exp);
    logic [7:0] b;
    int wait_n;
    wait_n = 0;
    b = '0;
    @(negedge clk);
    while (txd !== 1'b0 && wait_n < 2000) begin @(negedge clk); wait_n++; end
    chk({req, " start seen"}, 32'(wait_n < 2000), 32'd1);
    repeat (DIV / 2) @(negedge clk);
    chk({req, " start mid"}, 32'(txd), 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txd;
    end
    chk({req, " data"}, 32'(b), 32'(exp));
    repeat (DIV) @(negedge clk);
    chk({req, " stop"}, 32'(txd), 32'd1);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 txd idle", 32'(txd), 32'd1);
    chk("R12 irq lines", 32'({irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any}), 32'd0);
    rd_chk("R12 status", 12'h004, 32'h0);
    rd_chk("R12 control", 12'h008, 32'h0);
    rd_chk("R12 irqstat", 12'h00C, 32'h0);
    rd_chk("R12 divider", 12'h010, 32'h0);
    rd_chk("R12 data", 12'h000, 32'h0);
  endtask

  task automatic t_masks;
    bus_wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R1 control mask", 12'h008, 32'h7F);
    bus_wr(12'h008, 32'h0);
    bus_wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R10 divider mask", 12'h010, 32'hF_FFFF);
    bus_wr(12'h010, DIV);
  endtask

  task automatic t_tx_frame;
    bus_wr(12'h008, 32'h05);
    bus_wr(12'h000, 32'h1A5);
    line_grab("R3 frame", 8'hA5);
    rd_chk("R3 full cleared", 12'h004, 32'h0);
    rd_chk("R4 tx status", 12'h00C, 32'h1);
    chk("R11 irq_tx", 32'(irq_tx), 32'd1);
    chk("R11 irq_any", 32'(irq_any), 32'd1);
    bus_wr(12'h00C, 32'h1);
    chk("R9 tx status cleared", 32'({irq_tx, irq_any}), 32'd0);
    bus_wr(12'h008, 32'h0);
  endtask

  task automatic t_tx_overrun;
    bus_wr(12'h008, 32'h10);
    bus_wr(12'h000, 32'h11);
    rd_chk("R2 full", 12'h004, 32'h1);
    chk("R8 no overrun yet", 32'(irq_tx_ovr), 32'd0);
    bus_wr(12'h000, 32'h22);
    rd_chk("R2 overrun", 12'h004, 32'h5);
    rd_chk("R8 ovr status", 12'h00C, 32'h4);
    chk("R8 irq_tx_ovr", 32'({irq_tx_ovr, irq_any}), 32'h3);
    bus_wr(12'h008, 32'h00);
    chk("R8 enable off drops line", 32'(irq_tx_ovr), 32'd0);
    rd_chk("R8 flag kept", 12'h004, 32'h5);
    bus_wr(12'h008, 32'h10);
    chk("R8 enable on raises line", 32'(irq_tx_ovr), 32'd1);
    bus_wr(12'h004, 32'h4);
    rd_chk("R9 status w1c", 12'h004, 32'h1);
    chk("R9 line after status w1c", 32'(irq_tx_ovr), 32'd0);
    bus_wr(12'h000, 32'h33);
    chk("R2 second overrun", 32'(irq_tx_ovr), 32'd1);
    bus_wr(12'h00C, 32'h4);
    rd_chk("R9 irqstat w1c clears flag", 12'h004, 32'h1);
    bus_wr(12'h008, 32'h01);
    line_grab("R2 newest byte sent", 8'h33);
    rd_chk("R4 no status when disabled", 12'h00C, 32'h0);
    bus_wr(12'h008, 32'h0);
  endtask

  task automatic t_bad_div;
    int low_seen;
    low_seen = 0;
    bus_wr(12'h010, 32'd15);
    bus_wr(12'h008, 32'h01);
    bus_wr(12'h000, 32'h5A);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen++;
    end
    chk("R10 no frame below 16", 32'(low_seen), 32'd0);
    rd_chk("R10 byte still held", 12'h004, 32'h1);
    bus_wr(12'h010, DIV);
    line_grab("R10 sends once valid", 8'h5A);
    bus_wr(12'h008, 32'h0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    bus_wr(12'h008, 32'h0A);
    line_send(8'h3C);
    rd_chk("R5 rx full", 12'h004, 32'h2);
    rd_chk("R7 rx status", 12'h00C, 32'h2);
    chk("R11 irq_rx", 32'({irq_rx, irq_any}), 32'h3);
    bus_rd(12'h000, v);
    chk("R6 rx byte", v, 32'h3C);
    rd_chk("R6 full cleared", 12'h004, 32'h0);
    bus_wr(12'h00C, 32'h2);
    chk("R9 rx status cleared", 32'(irq_rx), 32'd0);
    bus_wr(12'h008, 32'h02);
    line_send(8'hC3);
    rd_chk("R7 no status without enable", 12'h00C, 32'h0);
    rd_chk("R6 second byte", 12'h000, 32'hC3);
  endtask

  task automatic t_rx_overrun;
    bus_wr(12'h008, 32'h22);
    line_send(8'h81);
    line_send(8'h7E);
    rd_chk("R5 rx overrun", 12'h004, 32'hA);
    rd_chk("R8 rx ovr status", 12'h00C, 32'h8);
    chk("R11 irq_rx_ovr", 32'({irq_rx_ovr, irq_any}), 32'h3);
    rd_chk("R5 first byte kept", 12'h000, 32'h81);
    bus_wr(12'h00C, 32'h8);
    rd_chk("R9 rx flag cleared", 12'h004, 32'h0);
    chk("R9 rx ovr line", 32'(irq_rx_ovr), 32'd0);
  endtask

  task automatic t_rx_blocked;
    bus_wr(12'h008, 32'h08);
    line_send(8'h55);
    rd_chk("R5 off ignored", 12'h004, 32'h0);
    rd_chk("R5 off data unchanged", 12'h000, 32'h81);
    bus_wr(12'h010, 32'd15);
    bus_wr(12'h008, 32'h0A);
    line_send(8'h66);
    rd_chk("R10 rx blocked", 12'h004, 32'h0);
    rd_chk("R10 rx no status", 12'h00C, 32'h0);
    bus_wr(12'h010, DIV);
    bus_wr(12'h008, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk("R12 unmapped 0x014", 12'h014, 32'h0);
    rd_chk("R12 unmapped 0x800", 12'h800, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_tx_frame();
    t_tx_overrun();
    t_bad_div();
    t_rx_basic();
    t_rx_overrun();
    t_rx_blocked();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule